// File: doc/BRIEF.md
# SDRAM Refresh Interval Timer

This block paces refresh for an SDRAM controller. A two-bit rate setting chooses one of three refresh intervals or turns refresh off, and a two-bit clock setting tells the block at which core frequency it runs. From these two settings the block derives, from a computed constant table, how many clock cycles make up one interval. The table values are rounded down to whole cycles.

Each time an interval runs out, the block raises a request for exactly one cycle. It also counts the refreshes that are owed. The command sequencer retires one owed refresh per cycle in which it asserts the acknowledge input. The owed count saturates instead of wrapping, so a slow sequencer loses no request until the counter is full.

Any change to either setting restarts the interval at once from the new length.

Top module: `rfsh_interval_timer`

## Requirements
- R1: When reset is asserted (active low, asynchronous), the request output and the owed count go to zero and the pending flag goes low. The internal copy of the settings reads as "off". If the rate input is nonzero when reset is released, the first rising edge treats it as a change (see R7).
- R2: With rate code 2'b01, the interval is floor(7.8 us × f) cycles, where f is the clock in MHz. This gives 514 cycles at 66 MHz, 780 at 100 MHz and 1037 at 133 MHz. Requests recur with exactly that period.
- R3: With rate code 2'b10, the interval is floor(15.6 us × f) cycles: 1029, 1560 and 2074.
- R4: With rate code 2'b11, the interval is floor(125 us × f) cycles: 8250, 12500 and 16625.
- R5: The clock code selects the frequency: 2'b00 is 66 MHz, 2'b01 is 100 MHz, 2'b10 is 133 MHz, and 2'b11 is treated as 133 MHz.
- R6: With rate code 2'b00, no request is ever raised, however long the code is held.
- R7: Suppose a rising edge samples a {rate, clock} pair that differs from the pair sampled at the previous edge. That edge raises no request and restarts the interval. With the new length N, the first request is high in the cycle after the N-th rising edge that follows that edge.
- R8: The request output is high for exactly one cycle per expired interval.
- R9: Each request adds one to the 3-bit owed count. Each acknowledge sampled while the count is nonzero subtracts one. The pending flag is high exactly when the owed count is nonzero.
- R10: The owed count stops at 7. Further requests are still issued, but the count stays at 7.
- R11: An acknowledge sampled while the owed count is zero has no effect. An acknowledge sampled at the same edge that raises a request leaves a nonzero count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Interval code: 00 off, 01 7.8 us, 10 15.6 us, 11 125 us |
| freq_sel | input | 2 | Clock code: 00 66 MHz, 01 100 MHz, 10/11 133 MHz |
| refresh_ack | input | 1 | Sequencer retires one owed refresh |
| refresh_req | output | 1 | One-cycle refresh request |
| refresh_pending | output | 1 | High while any refresh is owed |
| pending_count | output | 3 | Number of owed refreshes, saturating at 7 |

## Verification
The three interval codes are run at all four clock codes, including the code that falls back to 133 MHz. Exact request cycles are compared, so an off-by-one in the table or in the reload shows up as a shifted pulse.

A setting change in the middle of an interval tells a true restart apart from a counter that keeps running on the old length. A long stretch with rate 00 shows whether the off code really stops requests.

With acknowledges withheld, the requests pile up, which shows whether the owed count wraps or saturates. Acknowledges placed on a request edge and on an empty count separate the simultaneous and the ignored cases.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  // Cycles in one interval: floor(tenths_us * mhz / 10).
  function automatic int unsigned interval_cycles(input int unsigned tenths_us,
                                                  input int unsigned mhz);
    return (tenths_us * mhz) / 10;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  localparam logic [1:0] RATE_OFF = 2'b00;

endpackage

// File: rtl/rfsh_interval_lut.sv
module rfsh_interval_lut
  import rfsh_pkg::*;
#(
  parameter int unsigned F0_MHZ    = 66,
  parameter int unsigned F1_MHZ    = 100,
  parameter int unsigned F2_MHZ    = 133,
  parameter int unsigned T1_TENTHS = 78,
  parameter int unsigned T2_TENTHS = 156,
  parameter int unsigned T3_TENTHS = 1250,
  parameter int unsigned CNT_W     = 15
) (
  input  logic [1:0]       rate_code,
  input  logic [1:0]       freq_code,
  output logic [CNT_W-1:0] reload_val
);

  localparam int unsigned NFREQ = 3;
  localparam int unsigned NRATE = 3;

  logic [CNT_W-1:0] tbl [NRATE][NFREQ];

  // Compute the table entries from the rate and frequency parameters.
  for (genvar r = 0; r < NRATE; r++) begin : g_rate
    for (genvar f = 0; f < NFREQ; f++) begin : g_freq
      localparam int unsigned TN = (r == 0) ? T1_TENTHS : (r == 1) ? T2_TENTHS : T3_TENTHS;
      localparam int unsigned FM = (f == 0) ? F0_MHZ : (f == 1) ? F1_MHZ : F2_MHZ;
      localparam int unsigned NC = interval_cycles(TN, FM);
      assign tbl[r][f] = CNT_W'(NC);
    end
  end

  logic [1:0] f_idx;
  logic [1:0] r_idx;

  always_comb begin
    f_idx = (freq_code == 2'b11) ? 2'd2 : freq_code;
    r_idx = (rate_code == 2'b00) ? 2'd0 : 2'(rate_code - 2'd1);
    if (rate_code == 2'b00) begin
      reload_val = '0;
    end else begin
      reload_val = tbl[r_idx][f_idx];
    end
  end

endmodule

// File: rtl/rfsh_down_counter.sv
module rfsh_down_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] reload_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] reload_m1;

  always_comb begin
    reload_m1 = reload_val - CNT_W'(1);
    expire    = run && !load && (cnt_q == '0);
    cnt_en    = load || run;
    if (load || expire) begin
      cnt_d = reload_m1;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rfsh_pend_ctr.sv
module rfsh_pend_ctr #(
  parameter int unsigned PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              ack,
  output logic [PEND_W-1:0] count,
  output logic              pending
);

  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [PEND_W-1:0] cnt_q;
  logic [PEND_W-1:0] cnt_d;
  logic              dec;
  logic              cnt_en;

  always_comb begin
    dec    = ack && (cnt_q != '0);
    cnt_en = inc ^ dec;
    if (inc) begin
      cnt_d = (cnt_q == PEND_MAX) ? PEND_MAX : cnt_q + PEND_W'(1);
    end else begin
      cnt_d = cnt_q - PEND_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count   = cnt_q;
  assign pending = (cnt_q != '0);

endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer
  import rfsh_pkg::*;
#(
  parameter int unsigned F0_MHZ    = 66,
  parameter int unsigned F1_MHZ    = 100,
  parameter int unsigned F2_MHZ    = 133,
  parameter int unsigned T1_TENTHS = 78,
  parameter int unsigned T2_TENTHS = 156,
  parameter int unsigned T3_TENTHS = 1250,
  parameter int unsigned PEND_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate_sel,
  input  logic [1:0]        freq_sel,
  input  logic              refresh_ack,
  output logic              refresh_req,
  output logic              refresh_pending,
  output logic [PEND_W-1:0] pending_count
);

  localparam int unsigned MAX_CYC = interval_cycles(
      max3(T1_TENTHS, T2_TENTHS, T3_TENTHS), max3(F0_MHZ, F1_MHZ, F2_MHZ));
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

  logic [1:0]       rate_q, freq_q;
  logic [1:0]       rate_d, freq_d;
  logic             cfg_chg;
  logic             run;
  logic             expire;
  logic             req_q, req_d;
  logic [CNT_W-1:0] reload_val;

  always_comb begin
    cfg_chg = (rate_sel != rate_q) || (freq_sel != freq_q);
    rate_d  = rate_sel;
    freq_d  = freq_sel;
    run     = (rate_q != RATE_OFF) && !cfg_chg;
    req_d   = expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_OFF;
      freq_q <= 2'b00;
    end else if (cfg_chg) begin
      rate_q <= rate_d;
      freq_q <= freq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  rfsh_interval_lut #(
    .F0_MHZ(F0_MHZ), .F1_MHZ(F1_MHZ), .F2_MHZ(F2_MHZ),
    .T1_TENTHS(T1_TENTHS), .T2_TENTHS(T2_TENTHS), .T3_TENTHS(T3_TENTHS),
    .CNT_W(CNT_W)
  ) u_lut (
    .rate_code (rate_sel),
    .freq_code (freq_sel),
    .reload_val(reload_val)
  );

  rfsh_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_chg),
    .run       (run),
    .reload_val(reload_val),
    .expire    (expire)
  );

  rfsh_pend_ctr #(.PEND_W(PEND_W)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (expire),
    .ack    (refresh_ack),
    .count  (pending_count),
    .pending(refresh_pending)
  );

  assign refresh_req = req_q;

endmodule

// File: rtl/rfsh_interval_timer_chk.sv
module rfsh_interval_timer_chk #(
  parameter int unsigned PEND_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        rate_sel,
  input logic [1:0]        freq_sel,
  input logic              refresh_ack,
  input logic              refresh_req,
  input logic              refresh_pending,
  input logic [PEND_W-1:0] pending_count
);

  localparam logic [PEND_W-1:0] PMAX = '1;

  // R6: the off code never produces a request at the next edge.
  p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 2'b00) |=> !refresh_req);

  // R7: the edge that samples a new setting raises no request.
  p_reload_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ({rate_sel, freq_sel} != $past({rate_sel, freq_sel})) |=> !refresh_req);

  // R8: request is a single-cycle pulse.
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> !refresh_req);

  // R9: a raised request is always recorded as owed.
  p_req_owed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> (pending_count != '0) && refresh_pending);

  // R10: a full count holds without an acknowledge.
  p_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_count == PMAX && !refresh_ack) |=> (pending_count == PMAX));

  // R11: an acknowledge never raises the owed count.
  p_ack_no_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_ack && pending_count != '0) |=> (pending_count <= $past(pending_count)));

endmodule

bind rfsh_interval_timer rfsh_interval_timer_chk #(.PEND_W(PEND_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rate_sel       (rate_sel),
  .freq_sel       (freq_sel),
  .refresh_ack    (refresh_ack),
  .refresh_req    (refresh_req),
  .refresh_pending(refresh_pending),
  .pending_count  (pending_count)
);

// File: tb/rfsh_interval_timer_bench.sv
module rfsh_interval_timer_bench;

  logic       clk;
  logic       rst_n;
  logic [1:0] rate_sel;
  logic [1:0] freq_sel;
  logic       refresh_ack;
  logic       ack_auto;
  logic       ack_man;
  logic       auto_on;
  logic       refresh_req;
  logic       refresh_pending;
  logic [2:0] pending_count;

  int cyc;
  int n_cmp;
  int n_bad;
  int exp_q[$];
  bit done;

  assign refresh_ack = auto_on ? ack_auto : ack_man;

  rfsh_interval_timer u_rfsh_interval_timer (
    .clk            (clk),
    .rst_n          (rst_n),
    .rate_sel       (rate_sel),
    .freq_sel       (freq_sel),
    .refresh_ack    (refresh_ack),
    .refresh_req    (refresh_req),
    .refresh_pending(refresh_pending),
    .pending_count  (pending_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // Monitor: pops the expected request cycle whenever a pulse shows.
  initial ack_auto = 1'b0;
  always @(negedge clk) begin
    ack_auto <= 1'b0;
    if (rst_n && refresh_req) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6/R8 unexpected request", cyc, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R2-R5/R7 request cycle", cyc, e);
      end
      ack_auto <= 1'b1;
    end
  end

  // Driver: apply a setting at a negedge and queue the expected pulses.
  task automatic apply_cfg(input logic [1:0] r, input logic [1:0] f,
                           input int n, input int np);
    int c;
    rate_sel = r;
    freq_sel = f;
    c = cyc;
    for (int k = 1; k <= np; k++) exp_q.push_back(c + 1 + k * n);
  endtask

  task automatic run_cfg(input logic [1:0] r, input logic [1:0] f,
                         input int n, input int np, input string tag);
    apply_cfg(r, f, n, np);
    repeat (np * n + 2) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic wait_until(input int t);
    while (cyc != t) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack_man = 1'b1;
    @(negedge clk);
    ack_man = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int c;
    done = 0; n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; rate_sel = 2'b00; freq_sel = 2'b00;
    ack_man = 1'b0; auto_on = 1'b1;
    repeat (3) @(negedge clk);
    chk(refresh_req == 1'b0, "R1 reset request", refresh_req, 0);
    chk(pending_count == 3'd0, "R1 reset count", pending_count, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(refresh_pending == 1'b0, "R1 pending after reset", refresh_pending, 0);

    run_cfg(2'b01, 2'b00, 514, 3, "R2 7.8us at 66MHz");
    run_cfg(2'b10, 2'b01, 1560, 2, "R3 15.6us at 100MHz");
    run_cfg(2'b11, 2'b10, 16625, 1, "R4 125us at 133MHz");
    run_cfg(2'b01, 2'b11, 1037, 1, "R5 code 11 as 133MHz");
    run_cfg(2'b10, 2'b00, 1029, 1, "R3 15.6us at 66MHz");

    // R7: change in mid interval restarts with the new length.
    apply_cfg(2'b01, 2'b00, 514, 0);
    repeat (300) @(negedge clk);
    run_cfg(2'b01, 2'b01, 780, 1, "R7 reload on change");
    repeat (2) @(negedge clk);
    chk(pending_count == 3'd0, "R9 all acknowledged", pending_count, 0);

    // R6: off code stays quiet.
    apply_cfg(2'b00, 2'b00, 0, 0);
    repeat (20000) @(negedge clk);
    chk(exp_q.size() == 0 && refresh_req == 1'b0, "R6 off code", refresh_req, 0);

    // R10 / R11: let requests pile up.
    auto_on = 1'b0;
    c = cyc;
    apply_cfg(2'b01, 2'b00, 514, 10);
    wait_until(c + 1 + 9 * 514);
    chk(pending_count == 3'd7, "R10 saturate at 7", pending_count, 7);
    chk(refresh_pending == 1'b1, "R9 pending flag", refresh_pending, 1);
    pulse_ack();
    chk(pending_count == 3'd6, "R9 ack retires one", pending_count, 6);
    wait_until(c + 10 * 514);
    ack_man = 1'b1;
    @(negedge clk);
    ack_man = 1'b0;
    chk(pending_count == 3'd6, "R11 ack with request", pending_count, 6);
    rate_sel = 2'b00;
    @(negedge clk);
    for (int i = 0; i < 6; i++) pulse_ack();
    chk(pending_count == 3'd0, "R9 drained", pending_count, 0);
    chk(refresh_pending == 1'b0, "R9 flag low", refresh_pending, 0);
    pulse_ack();
    chk(pending_count == 3'd0, "R11 ack on empty", pending_count, 0);

    // R1: reset in the middle, rate held nonzero across release.
    c = cyc;
    apply_cfg(2'b01, 2'b00, 514, 1);
    wait_until(c + 1 + 514);
    @(negedge clk);
    chk(pending_count == 3'd1, "R9 count one", pending_count, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(pending_count == 3'd0 && refresh_pending == 1'b0, "R1 mid reset", pending_count, 0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_q.push_back(cyc + 1 + 514);
    repeat (520) @(negedge clk);
    chk(exp_q.size() == 0, "R1 restart after reset", exp_q.size(), 0);
    chk(pending_count == 3'd1, "R9 count after restart", pending_count, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule